// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

Two 8-bit up-counters, called the low unit and the high unit, each with a control byte and a compare byte written over a simple register port. The mode bits of the two control bytes together choose how the counters work. In stand-alone mode each unit counts on its own. In chained mode the pair forms one 16-bit counter that runs from the high unit's start bit.

Each unit picks its count rate from the system clock, either undivided or divided by 4. It can instead use an external input pin, which is synchronised, edge-detected and then divided by 1, 2, 4 or 8. Divided rates are single-cycle enable pulses in the system-clock domain. When a count equals its compare value, the next count event clears the count and toggles the unit's output flip-flop. An enable bit gates that flip-flop onto the unit's output pin. Writes that select a prohibited clock or mode leave the counters stopped and set a sticky error flag.

Top module: `dual_timer8`

## Requirements
- R1: After reset, both control bytes read 0x00, both counts are 0, both outputs are low and the error flag reads 0.
- R2: Write address 0 is the low control byte, 1 the high control byte, 2 the low compare and 3 the high compare. Control layout: bit 7 start, bits 6:4 clock select, bits 3:2 mode, bit 0 output enable. Bit 1 always reads back as 0. Read address 4 returns the error flag in bit 0, and other read addresses return 0.
- R3: Clearing the start bit stops the count and clears it to 0 on the following clock. Setting the start bit makes counting begin on the clock after the write.
- R4: Clock select 000 advances the count on every system clock, and 001 advances it on every fourth.
- R5: Clock select 010, 011, 100 and 101 advance the count once per 1, 2, 4 and 8 rising edges of the external input respectively. The input passes through a two-flop synchroniser first.
- R6: In stand-alone mode, a count event while the count equals the compare value clears the count to 0 and toggles the unit's output flip-flop. Any other count event increments the count, wrapping from 0xFF to 0x00.
- R7: A unit's output pin is low while its output enable bit is 0, and otherwise follows the unit's flip-flop. The flip-flop is 0 while the unit is stopped.
- R8: With low mode bits 01 and high mode bits 01 (chained), the pair counts as one 16-bit value {high, low} at the low unit's rate. The high unit's start bit alone starts, stops and clears both counts, and the low start bit is ignored. A 16-bit compare match clears both counts and toggles the high flip-flop.
- R9: Stand-alone mode needs low mode bit 2 to be 0 and high mode bits 00. Every pattern other than stand-alone or chained is reserved and keeps both counters stopped at 0. Clock codes 110 and 111 keep their unit stopped. A control write with the start bit set that selects either of these sets the error flag, which stays set until reset.
- R10: Read data appears one clock after the read address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| ext_in | input | 1 | External count input, asynchronous |
| rd_data | output | 8 | Registered read data |
| cnt_lo | output | 8 | Low unit count |
| cnt_hi | output | 8 | High unit count |
| tmr_out_lo | output | 1 | Low unit timer output |
| tmr_out_hi | output | 1 | High unit timer output |

## Verification
The counters are driven at the undivided system rate, at the divided-by-4 rate, and by a train of external pulses under each of the four external divisors. The same pulse train yields 16, 8, 4 and 2 counts, so an off-by-one divisor or a double-counted edge stands out. Compare values of 2 and 5 in stand-alone mode, and a 16-bit compare of 0x0102 in chained mode, show the difference between an inclusive match and a wrap. The chained run also shows the carry from the low count into the high count. Writes of reserved modes and prohibited clock codes, and a low start bit set while the high unit is idle, confirm that counting stays stopped and that the error flag stays set.

// File: rtl/dual_timer8_pkg.sv
package dual_timer8_pkg;

  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    MODE_SOLO  = 2'd0,
    MODE_CHAIN = 2'd1,
    MODE_BAD   = 2'd2
  } mode_e;

  // count events per advance for each clock code
  function automatic logic [3:0] div_ratio(input logic [2:0] sel);
    case (sel)
      3'd1:    div_ratio = 4'd4;
      3'd3:    div_ratio = 4'd2;
      3'd4:    div_ratio = 4'd4;
      3'd5:    div_ratio = 4'd8;
      default: div_ratio = 4'd1;
    endcase
  endfunction

  function automatic logic sel_ok(input logic [2:0] sel);
    sel_ok = (sel <= 3'd5);
  endfunction

  function automatic logic sel_ext(input logic [2:0] sel);
    sel_ext = (sel >= 3'd2) && (sel <= 3'd5);
  endfunction

  function automatic mode_e decode_mode(input logic [1:0] lo_md, input logic [1:0] hi_md);
    if (!lo_md[0] && hi_md == 2'b00)
      decode_mode = MODE_SOLO;
    else if (lo_md == 2'b01 && hi_md == 2'b01)
      decode_mode = MODE_CHAIN;
    else
      decode_mode = MODE_BAD;
  endfunction

endpackage

// File: rtl/dt_regs.sv
module dt_regs
  import dual_timer8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int AW    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [CTRL_W-1:0] ctrl_lo,
  output logic [CTRL_W-1:0] ctrl_hi,
  output logic [CNT_W-1:0]  cmp_lo,
  output logic [CNT_W-1:0]  cmp_hi,
  output logic [CNT_W-1:0]  rd_data,
  output logic              err
);

  logic bad_lo, bad_hi;

  always_comb begin
    bad_lo = wr_data[7] && (!sel_ok(wr_data[6:4]) ||
             decode_mode(wr_data[3:2], ctrl_hi[3:2]) == MODE_BAD);
    bad_hi = wr_data[7] && (!sel_ok(wr_data[6:4]) ||
             decode_mode(ctrl_lo[3:2], wr_data[3:2]) == MODE_BAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_lo <= '0;
      ctrl_hi <= '0;
      cmp_lo  <= '0;
      cmp_hi  <= '0;
      err     <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(0): begin
          ctrl_lo <= {wr_data[7:2], 1'b0, wr_data[0]};
          if (bad_lo) err <= 1'b1;
        end
        AW'(1): begin
          ctrl_hi <= {wr_data[7:2], 1'b0, wr_data[0]};
          if (bad_hi) err <= 1'b1;
        end
        AW'(2): cmp_lo <= CNT_W'(wr_data);
        AW'(3): cmp_hi <= CNT_W'(wr_data);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        AW'(0):  rd_data <= CNT_W'(ctrl_lo);
        AW'(1):  rd_data <= CNT_W'(ctrl_hi);
        AW'(2):  rd_data <= cmp_lo;
        AW'(3):  rd_data <= cmp_hi;
        AW'(4):  rd_data <= CNT_W'(err);
        default: rd_data <= '0;
      endcase
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err |=> err); // R9
  AST_BIT1_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) <= AW'(1)) |-> (rd_data[1] == 1'b0)); // R2

endmodule

// File: rtl/dt_prescale.sv
module dt_prescale
  import dual_timer8_pkg::*;
#(
  parameter int PCW = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] sel,
  input  logic       ext_rise,
  output logic       tick
);

  logic [PCW-1:0] pc;
  logic [PCW-1:0] lim;
  logic           ev;

  always_comb begin
    lim  = PCW'(div_ratio(sel) - 4'd1);
    ev   = sel_ext(sel) ? ext_rise : 1'b1;
    tick = run && ev && (pc == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pc <= '0;
    else if (ev)     pc <= (pc == lim) ? '0 : pc + 1'b1;
  end

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (rst) tick |=> (pc == '0)); // R4

endmodule

// File: rtl/dt_core.sv
module dt_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chain,
  input  logic             run_lo,
  input  logic             run_hi,
  input  logic             tick_lo,
  input  logic             tick_hi,
  input  logic [CNT_W-1:0] cmp_lo,
  input  logic [CNT_W-1:0] cmp_hi,
  output logic [CNT_W-1:0] cnt_lo,
  output logic [CNT_W-1:0] cnt_hi,
  output logic             ff_lo,
  output logic             ff_hi
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      ff_lo  <= 1'b0;
      ff_hi  <= 1'b0;
    end else if (chain) begin
      ff_lo <= 1'b0;
      if (!run_hi) begin
        cnt_lo <= '0;
        cnt_hi <= '0;
        ff_hi  <= 1'b0;
      end else if (tick_lo) begin
        if ({cnt_hi, cnt_lo} == {cmp_hi, cmp_lo}) begin
          cnt_lo <= '0;
          cnt_hi <= '0;
          ff_hi  <= ~ff_hi;
        end else begin
          cnt_lo <= cnt_lo + 1'b1;
          if (&cnt_lo) cnt_hi <= cnt_hi + 1'b1;
        end
      end
    end else begin
      if (!run_lo) begin
        cnt_lo <= '0;
        ff_lo  <= 1'b0;
      end else if (tick_lo) begin
        if (cnt_lo == cmp_lo) begin
          cnt_lo <= '0;
          ff_lo  <= ~ff_lo;
        end else cnt_lo <= cnt_lo + 1'b1;
      end
      if (!run_hi) begin
        cnt_hi <= '0;
        ff_hi  <= 1'b0;
      end else if (tick_hi) begin
        if (cnt_hi == cmp_hi) begin
          cnt_hi <= '0;
          ff_hi  <= ~ff_hi;
        end else cnt_hi <= cnt_hi + 1'b1;
      end
    end
  end

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !run_lo |=> (cnt_lo == '0)); // R3
  AST_SOLO_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!chain && run_lo && tick_lo && cnt_lo == cmp_lo) |=> (cnt_lo == '0 && ff_lo != $past(ff_lo))); // R6
  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (chain && !tick_lo) |=> ($stable(cnt_hi) || cnt_hi == '0)); // R8

endmodule

// File: rtl/dual_timer8.sv
module dual_timer8
  import dual_timer8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int AW    = 3,
  parameter int PCW   = 4,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic             ext_in,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] cnt_lo,
  output logic [CNT_W-1:0] cnt_hi,
  output logic             tmr_out_lo,
  output logic             tmr_out_hi
);

  localparam int SW = SYNC + 1;

  logic [CTRL_W-1:0] ctrl_lo, ctrl_hi;
  logic [CNT_W-1:0]  cmp_lo, cmp_hi;
  logic              err;
  logic [SW-1:0]     ext_s;
  logic              ext_rise;
  logic              solo, chain;
  logic [1:0]        run, tick;
  logic [2:0]        sel [2];
  logic              ff_lo, ff_hi;

  dt_regs #(.CNT_W(CNT_W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ctrl_lo(ctrl_lo), .ctrl_hi(ctrl_hi), .cmp_lo(cmp_lo),
    .cmp_hi(cmp_hi), .rd_data(rd_data), .err(err)
  );

  always_ff @(posedge clk) begin
    if (rst) ext_s <= '0;
    else     ext_s <= {ext_s[SW-2:0], ext_in};
  end
  assign ext_rise = ext_s[SW-2] & ~ext_s[SW-1];

  always_comb begin
    solo   = decode_mode(ctrl_lo[3:2], ctrl_hi[3:2]) == MODE_SOLO;
    chain  = decode_mode(ctrl_lo[3:2], ctrl_hi[3:2]) == MODE_CHAIN;
    sel[0] = ctrl_lo[6:4];
    sel[1] = ctrl_hi[6:4];
    run[0] = sel_ok(sel[0]) && ((solo && ctrl_lo[7]) || (chain && ctrl_hi[7]));
    run[1] = ctrl_hi[7] && ((solo && sel_ok(sel[1])) || (chain && sel_ok(sel[0])));
  end

  for (genvar u = 0; u < 2; u++) begin : g_pre
    dt_prescale #(.PCW(PCW)) u_pre (
      .clk(clk), .rst(rst), .run(run[u]), .sel(sel[u]),
      .ext_rise(ext_rise), .tick(tick[u])
    );
  end

  dt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .chain(chain), .run_lo(run[0]), .run_hi(run[1]),
    .tick_lo(tick[0]), .tick_hi(tick[1]), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ff_lo(ff_lo), .ff_hi(ff_hi)
  );

  assign tmr_out_lo = ctrl_lo[0] & ff_lo;
  assign tmr_out_hi = ctrl_hi[0] & ff_hi;

  AST_LO_CE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (chain && !ctrl_hi[7]) |=> (cnt_lo == '0)); // R8
  AST_BAD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!solo && !chain) |=> (cnt_lo == '0 && cnt_hi == '0)); // R9

endmodule

// File: tb/dual_timer8_test.sv
module dual_timer8_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic       ext_in = 1'b0;
  logic [7:0] rd_data, cnt_lo, cnt_hi;
  logic       tmr_out_lo, tmr_out_hi;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  dual_timer8 uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ext_in(ext_in), .rd_data(rd_data), .cnt_lo(cnt_lo),
    .cnt_hi(cnt_hi), .tmr_out_lo(tmr_out_lo), .tmr_out_hi(tmr_out_hi)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mc[2], mp[2], mcn[2], mff[2], mpc[2];
  int merr, mrd, ms0, ms1, ms2;

  function automatic int ratio(input int s);
    if (s == 1 || s == 4) return 4;
    if (s == 3) return 2;
    if (s == 5) return 8;
    return 1;
  endfunction

  function automatic bit mode_solo(input int l, input int h);
    return ((l & 1) == 0) && (h == 0);
  endfunction

  function automatic bit mode_chain(input int l, input int h);
    return (l == 1) && (h == 1);
  endfunction

  always @(posedge clk) begin : model
    int lmd, hmd, s[2], n, full, cfull;
    bit so, ch, hce, rise, ev;
    bit r[2], tk[2];
    if (rst) begin
      for (int u = 0; u < 2; u++) begin
        mc[u] = 0; mp[u] = 0; mcn[u] = 0; mff[u] = 0; mpc[u] = 0;
      end
      merr = 0; mrd = 0; ms0 = 0; ms1 = 0; ms2 = 0;
    end else begin
      lmd = (mc[0] >> 2) & 3;
      hmd = (mc[1] >> 2) & 3;
      so  = mode_solo(lmd, hmd);
      ch  = mode_chain(lmd, hmd);
      s[0] = (mc[0] >> 4) & 7;
      s[1] = (mc[1] >> 4) & 7;
      hce = (mc[1] >> 7) & 1;
      r[0] = (s[0] <= 5) && ((so && ((mc[0] >> 7) & 1)) || (ch && hce));
      r[1] = hce && ((so && s[1] <= 5) || (ch && s[0] <= 5));
      rise = ms1 && !ms2;
      for (int u = 0; u < 2; u++) begin
        n  = ratio(s[u]);
        ev = (s[u] >= 2 && s[u] <= 5) ? rise : 1'b1;
        tk[u] = r[u] && ev && (mpc[u] == n - 1);
        if (!r[u]) mpc[u] = 0;
        else if (ev) mpc[u] = (mpc[u] == n - 1) ? 0 : mpc[u] + 1;
      end
      if (ch) begin
        mff[0] = 0;
        if (!r[1]) begin mcn[0] = 0; mcn[1] = 0; mff[1] = 0; end
        else if (tk[0]) begin
          full  = mcn[1] * 256 + mcn[0];
          cfull = mp[1] * 256 + mp[0];
          if (full == cfull) begin mcn[0] = 0; mcn[1] = 0; mff[1] ^= 1; end
          else begin full = (full + 1) % 65536; mcn[0] = full % 256; mcn[1] = full / 256; end
        end
      end else begin
        for (int u = 0; u < 2; u++) begin
          if (!r[u]) begin mcn[u] = 0; mff[u] = 0; end
          else if (tk[u]) begin
            if (mcn[u] == mp[u]) begin mcn[u] = 0; mff[u] ^= 1; end
            else mcn[u] = (mcn[u] + 1) % 256;
          end
        end
      end
      case (rd_addr)
        0: mrd = mc[0];
        1: mrd = mc[1];
        2: mrd = mp[0];
        3: mrd = mp[1];
        4: mrd = merr;
        default: mrd = 0;
      endcase
      if (wr_en) begin
        if (wr_addr <= 1) begin
          int d, nl, nh;
          d  = int'(wr_data) & 8'hFD;
          nl = (wr_addr == 0) ? ((d >> 2) & 3) : lmd;
          nh = (wr_addr == 1) ? ((d >> 2) & 3) : hmd;
          if (((d >> 7) & 1) && ((((d >> 4) & 7) > 5) ||
              !(mode_solo(nl, nh) || mode_chain(nl, nh)))) merr = 1;
          mc[wr_addr] = d;
        end else if (wr_addr <= 3) mp[wr_addr - 2] = int'(wr_data);
      end
      ms2 = ms1; ms1 = ms0; ms0 = int'(ext_in);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "cnt_lo", int'(cnt_lo), mcn[0]);
      chk(cur_req, "cnt_hi", int'(cnt_hi), mcn[1]);
      chk(cur_req, "out_lo", int'(tmr_out_lo), (mc[0] & 1) & mff[0]);
      chk(cur_req, "out_hi", int'(tmr_out_hi), (mc[1] & 1) & mff[1]);
      chk(cur_req, "rd_data", int'(rd_data), mrd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "read", int'(rd_data), exp);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_in = 1'b1;
      repeat (2) @(negedge clk);
      ext_in = 1'b0;
      repeat (2) @(negedge clk);
    end
    step(6);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cur_req = "R1";
    chk("R1", "cnt_lo", int'(cnt_lo), 0);
    chk("R1", "cnt_hi", int'(cnt_hi), 0);
    chk("R1", "out_lo", int'(tmr_out_lo), 0);
    rd_chk("R1", 3'd0, 0);
    rd_chk("R1", 3'd4, 0);

    // R2 register layout, bit 1 forced to zero; R10 read latency
    cur_req = "R2";
    wr(3'd0, 8'h0F);
    rd_chk("R2", 3'd0, 8'h0D);
    wr(3'd2, 8'hA5);
    rd_chk("R10", 3'd2, 8'hA5);
    rd_chk("R2", 3'd6, 0);
    wr(3'd0, 8'h00);
    rd_addr = 3'd7;

    // R3 / R4 system clock, start and stop
    cur_req = "R3";
    wr(3'd2, 8'd5);
    wr(3'd0, 8'h81);
    step(3);
    chk("R3", "cnt_lo after start", int'(cnt_lo), 3);
    step(20);
    wr(3'd0, 8'h01);
    step(1);
    chk("R3", "cnt_lo after stop", int'(cnt_lo), 0);
    cur_req = "R4";
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h91);
    step(8);
    chk("R4", "cnt_lo div4", int'(cnt_lo), 2);
    step(40);
    wr(3'd0, 8'h01);

    // R5 external input with four divisors
    cur_req = "R5";
    begin
      logic [7:0] codes [4] = '{8'hA1, 8'hB1, 8'hC1, 8'hD1};
      int         expv  [4] = '{16, 8, 4, 2};
      for (int k = 0; k < 4; k++) begin
        wr(3'd0, codes[k]);
        pulses(16);
        chk("R5", "cnt_lo ext", int'(cnt_lo), expv[k]);
        wr(3'd0, 8'h01);
        step(2);
      end
    end

    // R6 / R7 compare toggle and output gating
    cur_req = "R6";
    wr(3'd2, 8'd2);
    wr(3'd0, 8'h81);
    step(3);
    chk("R6", "cnt_lo wrapped at compare", int'(cnt_lo), 0);
    chk("R7", "out_lo toggled", int'(tmr_out_lo), 1);
    cur_req = "R7";
    wr(3'd0, 8'h80);
    chk("R7", "out_lo disabled", int'(tmr_out_lo), 0);
    step(10);
    wr(3'd3, 8'd3);
    wr(3'd1, 8'h81);
    step(25);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    step(2);

    // R8 chained 16-bit mode
    cur_req = "R8";
    wr(3'd2, 8'h02);
    wr(3'd3, 8'h01);
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h84);
    step(5);
    chk("R8", "low start ignored", int'(cnt_lo), 0);
    wr(3'd1, 8'h85);
    step(256);
    chk("R8", "carry cnt_lo", int'(cnt_lo), 0);
    chk("R8", "carry cnt_hi", int'(cnt_hi), 1);
    step(3);
    chk("R8", "16-bit match clears", int'(cnt_hi) * 256 + int'(cnt_lo), 0);
    chk("R8", "out_hi toggled", int'(tmr_out_hi), 1);
    step(20);
    rd_chk("R8", 3'd4, 0);

    // R9 prohibited codes
    cur_req = "R9";
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'hE1);
    step(4);
    chk("R9", "bad clock stopped", int'(cnt_lo), 0);
    rd_chk("R9", 3'd4, 1);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h8C);
    step(4);
    chk("R9", "reserved mode stopped", int'(cnt_hi), 0);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h81);
    step(4);
    rd_chk("R9", 3'd4, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule